// File: doc/BRIEF.md
# SDRAM Command Pattern Sequencer

This block plays fixed, slot-exact DDR SDRAM command loops that stress a memory device during supply-current characterization. It does not schedule real requests. It repeats one of two scripts for as long as it is enabled. The first cycles a single bank through activate, read and precharge. The second interleaves activates and reads-with-autoprecharge across four banks. A speed-grade input sets the loop length and the command spacing. The block also reports the CAS latency of the selected grade so that downstream capture logic can use it.

Each clock the block drives one command code, a bank address, a row and a column address, and a flag that asks the data path to toggle half of its bits on a read transfer. A 16-bit LFSR gives the addresses of each loop, so every repetition touches new locations while the slot timing stays the same. A pulse marks the first slot of every loop, so that external logic can align to it.

Top module: `sdr_pattern_seq`

## Requirements
- R1: With mode 0 and grade 0 (133 MHz) or grade 1 (166 MHz), the loop is 9 slots long: ACT at slot 0, RD at slot 3, PRE at slot 5, and NOP on every other slot, all to bank 0. Command codes: NOP=0, ACT=1, RD=2, RDA=3, PRE=4.
- R2: With mode 0 and grade 2 (200 MHz), the loop is 11 slots long: ACT at slot 0, RD at slot 3, PRE at slot 8, and NOP elsewhere, all to bank 0. Grade 3 behaves exactly like grade 2.
- R3: With mode 1, the loop is 10 slots long at grades 0 and 1, and 11 slots long at grades 2 and 3. It runs ACT b0 at slot 0, ACT b1 at slot 2, RDA b0 at slot 3, ACT b2 at slot 4, RDA b1 at slot 5, ACT b3 at slot 6, RDA b2 at slot 7 and RDA b3 at slot 9, with NOP on the remaining slots.
- R4: cas_o gives the CAS latency of the running loop in half clocks: 4 for grade 0, 5 for grade 1, 6 for grades 2 and 3. It is 4 after reset and changes only in the output cycle of slot 0.
- R5: loop_start_o is high exactly in the output cycle of slot 0.
- R6: The LFSR shifts left once at every loop start, with feedback bits 15^13^12^10 entering bit 0, starting from seed 0xACE1 after reset. On every non-NOP slot, row_o is LFSR[11:0] and col_o is LFSR[15:7] of the current loop's value.
- R7: On a NOP slot in mode 0, row_o and col_o both invert their previous values. On a NOP slot in mode 1, row_o, col_o and bank_o keep their previous values.
- R8: toggle_o is high only on RD and RDA slots.
- R9: mode_i and grade_i are sampled only when slot 0 is issued. A change in the middle of a loop takes effect at the next loop.
- R10: While rst_n is low at a clock edge, the outputs after that edge are NOP, bank 0, row 0, column 0, and toggle and loop_start are low. The next enabled cycle issues slot 0.
- R11: While en is low, the output is NOP with toggle and loop_start low, addresses and bank are held, and neither the slot position nor the LFSR advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Advance enable; low forces NOP and freezes the slot |
| mode_i | input | 1 | 0 single-bank loop, 1 four-bank interleaved loop |
| grade_i | input | 2 | Speed grade: 0 133 MHz, 1 166 MHz, 2/3 200 MHz |
| cmd_o | output | 3 | Command code |
| bank_o | output | 2 | Bank address |
| row_o | output | 12 | Row address |
| col_o | output | 9 | Column address |
| toggle_o | output | 1 | Request toggling of half the data bits |
| loop_start_o | output | 1 | High in the first slot of each loop |
| cas_o | output | 3 | CAS latency of the running loop, in half clocks |

## Verification
Every output is registered once. A command, address or flag chosen at a rising edge is visible from that edge on, and the bench reads it at the next falling edge. The bench keeps its own slot counter, configuration and LFSR, and updates them at each rising edge from the inputs it drove half a cycle earlier. The effect of a reset, an enable drop or a new grade therefore appears in the very next compare, or at the next loop start for a mid-loop change. The bench sweeps both modes over all four grades, with mid-loop changes, enable gaps and a mid-run reset.

// File: rtl/sdr_pattern_pkg.sv
// Shared types and script tables for the command pattern sequencer.
// Assumes grade codes 0..3, where code 3 is treated as the fastest grade.
package sdr_pattern_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_RDA = 3'd3,
        CMD_PRE = 3'd4
    } cmd_t;

    localparam int SLOT_W = 4;

    // Number of slots in one loop for a mode/grade pair.
    function automatic logic [SLOT_W-1:0] loop_len(input logic mode, input logic [1:0] grade);
        logic fast;
        fast = grade[1];
        if (mode) return fast ? 4'd11 : 4'd10;
        return fast ? 4'd11 : 4'd9;
    endfunction

    // CAS latency in half clocks for a grade.
    function automatic logic [2:0] cas_half(input logic [1:0] grade);
        case (grade)
            2'd0:    return 3'd4;
            2'd1:    return 3'd5;
            default: return 3'd6;
        endcase
    endfunction

endpackage

// File: rtl/sdr_pat_script.sv
// Combinational script lookup: gives the command, the bank and the
// last-slot flag for one slot of the selected loop.
// Assumes the slot is always below the loop length of the given mode and grade.
module sdr_pat_script
    import sdr_pattern_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic              mode,
    input  logic [1:0]        grade,
    input  logic [SLOT_W-1:0] slot,
    output cmd_t              cmd,
    output logic [BANK_W-1:0] bank,
    output logic              last
);
    localparam int PRE_SLOW = 5;
    localparam int PRE_FAST = 8;

    // Decode the slot into a command and a bank.
    always_comb begin
        cmd  = CMD_NOP;
        bank = '0;
        if (!mode) begin
            if (slot == 4'd0) cmd = CMD_ACT;
            else if (slot == 4'd3) cmd = CMD_RD;
            else if (slot == (grade[1] ? SLOT_W'(PRE_FAST) : SLOT_W'(PRE_SLOW))) cmd = CMD_PRE;
        end else begin
            case (slot)
                4'd0: begin cmd = CMD_ACT; bank = BANK_W'(0); end
                4'd2: begin cmd = CMD_ACT; bank = BANK_W'(1); end
                4'd3: begin cmd = CMD_RDA; bank = BANK_W'(0); end
                4'd4: begin cmd = CMD_ACT; bank = BANK_W'(2); end
                4'd5: begin cmd = CMD_RDA; bank = BANK_W'(1); end
                4'd6: begin cmd = CMD_ACT; bank = BANK_W'(3); end
                4'd7: begin cmd = CMD_RDA; bank = BANK_W'(2); end
                4'd9: begin cmd = CMD_RDA; bank = BANK_W'(3); end
                default: ;
            endcase
        end
    end

    // Flag the final slot of the loop.
    always_comb last = (slot == loop_len(mode, grade) - 4'd1);

endmodule

// File: rtl/sdr_pat_lfsr.sv
// Fibonacci LFSR that steps on request; gives both the current and the next value.
// Assumes a nonzero seed; the tap set is chosen by width.
module sdr_pat_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] value_o,
    output logic [W-1:0] next_o
);
    logic fb;

    generate
        if (W == 16) begin : g_t16
            // Feedback for the 16-bit polynomial.
            always_comb fb = value_o[15] ^ value_o[13] ^ value_o[12] ^ value_o[10];
        end else begin : g_t32
            // Feedback for the 32-bit polynomial.
            always_comb fb = value_o[31] ^ value_o[21] ^ value_o[1] ^ value_o[0];
        end
    endgenerate

    // Form the shifted value.
    always_comb next_o = {value_o[W-2:0], fb};

    // Hold or step the state.
    always_ff @(posedge clk) begin
        if (!rst_n)    value_o <= SEED;
        else if (step) value_o <= next_o;
    end

    // R6
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        value_o != '0);

endmodule

// File: rtl/sdr_pattern_seq.sv
// Top level: steps a slot counter through the selected loop script and
// registers the command, bank, addresses, toggle flag, loop-start pulse and
// CAS latency. The mode and the grade are captured only at slot 0.
// Assumes a single clock domain and a synchronous active-low reset.
module sdr_pattern_seq
    import sdr_pattern_pkg::*;
#(
    parameter int ROW_W  = 12,
    parameter int COL_W  = 9,
    parameter int BANK_W = 2,
    parameter int LFSR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              mode_i,
    input  logic [1:0]        grade_i,
    output logic [2:0]        cmd_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [ROW_W-1:0]  row_o,
    output logic [COL_W-1:0]  col_o,
    output logic              toggle_o,
    output logic              loop_start_o,
    output logic [2:0]        cas_o
);
    localparam logic [LFSR_W-1:0] SEED = LFSR_W'(16'hACE1);

    logic [SLOT_W-1:0] slot_q;
    logic              mode_q;
    logic [1:0]        grade_q;
    logic              at_start;
    logic              cur_mode;
    logic [1:0]        cur_grade;
    cmd_t              s_cmd;
    logic [BANK_W-1:0] s_bank;
    logic              s_last;
    logic [LFSR_W-1:0] lfsr_val, lfsr_nxt, lfsr_cur;

    // Pick the live configuration: the inputs at a loop start, else the latched values.
    always_comb begin
        at_start  = (slot_q == '0);
        cur_mode  = at_start ? mode_i  : mode_q;
        cur_grade = at_start ? grade_i : grade_q;
        lfsr_cur  = at_start ? lfsr_nxt : lfsr_val;
    end

    sdr_pat_script #(.BANK_W(BANK_W)) i_script (
        .mode  (cur_mode),
        .grade (cur_grade),
        .slot  (slot_q),
        .cmd   (s_cmd),
        .bank  (s_bank),
        .last  (s_last)
    );

    sdr_pat_lfsr #(.W(LFSR_W), .SEED(SEED)) i_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (en && at_start),
        .value_o (lfsr_val),
        .next_o  (lfsr_nxt)
    );

    // Step the slot, capture the configuration and register every output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q       <= '0;
            mode_q       <= 1'b0;
            grade_q      <= 2'd0;
            cmd_o        <= CMD_NOP;
            bank_o       <= '0;
            row_o        <= '0;
            col_o        <= '0;
            toggle_o     <= 1'b0;
            loop_start_o <= 1'b0;
            cas_o        <= cas_half(2'd0);
        end else if (!en) begin
            cmd_o        <= CMD_NOP;
            toggle_o     <= 1'b0;
            loop_start_o <= 1'b0;
        end else begin
            slot_q       <= s_last ? '0 : slot_q + 1'b1;
            cmd_o        <= s_cmd;
            toggle_o     <= (s_cmd == CMD_RD) || (s_cmd == CMD_RDA);
            loop_start_o <= at_start;
            if (at_start) begin
                mode_q  <= mode_i;
                grade_q <= grade_i;
                cas_o   <= cas_half(grade_i);
            end
            if (s_cmd != CMD_NOP) begin
                bank_o <= s_bank;
                row_o  <= lfsr_cur[ROW_W-1:0];
                col_o  <= lfsr_cur[LFSR_W-1 -: COL_W];
            end else if (!cur_mode) begin
                row_o <= ~row_o;
                col_o <= ~col_o;
            end
        end
    end

    // R10
    rst_nop_chk: assert property (@(posedge clk)
        !rst_n |=> (cmd_o == CMD_NOP) && !loop_start_o);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cmd_o == CMD_NOP) && $stable(row_o) && $stable(col_o) && $stable(bank_o));

    // R5
    start_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loop_start_o |-> (cmd_o == CMD_ACT) && (bank_o == '0));

    // R4
    cas_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_o == 3'd4) || (cas_o == 3'd5) || (cas_o == 3'd6));

    // R8
    toggle_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        toggle_o |-> (cmd_o == CMD_RD) || (cmd_o == CMD_RDA));

    // R4
    cas_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_start_o |=> $stable(cas_o) || loop_start_o);

endmodule

// File: tb/test_sdr_pattern_seq.sv
module test_sdr_pattern_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic mode_i = 1'b0;
    logic [1:0] grade_i = 2'd0;
    logic [2:0] cmd_o;
    logic [1:0] bank_o;
    logic [11:0] row_o;
    logic [8:0] col_o;
    logic toggle_o, loop_start_o;
    logic [2:0] cas_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sdr_pattern_seq i_sdr_pattern_seq (
        .clk(clk), .rst_n(rst_n), .en(en), .mode_i(mode_i), .grade_i(grade_i),
        .cmd_o(cmd_o), .bank_o(bank_o), .row_o(row_o), .col_o(col_o),
        .toggle_o(toggle_o), .loop_start_o(loop_start_o), .cas_o(cas_o)
    );

    // Reference model state
    int s = 0;
    bit m_mode = 0;
    int m_grade = 0;
    logic [15:0] lf = 16'hACE1;
    int e_cmd = 0, e_bank = 0, e_row = 0, e_col = 0, e_tog = 0, e_ls = 0, e_cas = 4;
    string t_cmd = "R10", t_addr = "R10";
    bit model_valid = 0;

    function automatic int len_of(bit m, int g);
        if (m) return (g >= 2) ? 11 : 10;
        return (g >= 2) ? 11 : 9;
    endfunction

    // Script from R1, R2 and R3; returns command code, bank in bits [5:4]
    function automatic int script(bit m, int g, int sl);
        if (!m) begin
            if (sl == 0) return 1;
            if (sl == 3) return 2;
            if (sl == ((g >= 2) ? 8 : 5)) return 4;
            return 0;
        end
        case (sl)
            0: return 1 | (0 << 4);
            2: return 1 | (1 << 4);
            3: return 3 | (0 << 4);
            4: return 1 | (2 << 4);
            5: return 3 | (1 << 4);
            6: return 1 | (3 << 4);
            7: return 3 | (2 << 4);
            9: return 3 | (3 << 4);
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        cycles++;
        model_valid = 1;
        if (!rst_n) begin
            // R10
            s = 0; m_mode = 0; m_grade = 0; lf = 16'hACE1;
            e_cmd = 0; e_bank = 0; e_row = 0; e_col = 0; e_tog = 0; e_ls = 0; e_cas = 4;
            t_cmd = "R10"; t_addr = "R10";
        end else if (!en) begin
            // R11
            e_cmd = 0; e_tog = 0; e_ls = 0;
            t_cmd = "R11"; t_addr = "R11";
        end else begin
            int sc, b, c;
            if (s == 0) begin
                // R9: capture only at slot 0
                m_mode = mode_i; m_grade = grade_i;
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                e_cas = (m_grade == 0) ? 4 : (m_grade == 1) ? 5 : 6;
            end
            sc = script(m_mode, m_grade, s);
            c = sc & 7; b = sc >> 4;
            e_cmd = c;
            e_tog = (c == 2 || c == 3) ? 1 : 0;
            e_ls = (s == 0) ? 1 : 0;
            if (c != 0) begin
                e_bank = b; e_row = lf[11:0]; e_col = lf[15:7]; t_addr = "R6";
            end else begin
                if (!m_mode) begin
                    e_row = ~e_row & 12'hFFF; e_col = ~e_col & 9'h1FF;
                end
                t_addr = "R7";
            end
            if (s != 0 && (mode_i != m_mode || grade_i != m_grade)) t_cmd = "R9";
            else if (m_mode) t_cmd = "R3";
            else if (m_grade >= 2) t_cmd = "R2";
            else t_cmd = "R1";
            s = (s + 1 == len_of(m_mode, m_grade)) ? 0 : s + 1;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (model_valid && !done) begin
            chk(t_cmd, "cmd", cmd_o, e_cmd);
            chk(t_addr, "bank", bank_o, e_bank);
            chk(t_addr, "row", row_o, e_row);
            chk(t_addr, "col", col_o, e_col);
            chk("R8", "toggle", toggle_o, e_tog);
            chk("R5", "loop_start", loop_start_o, e_ls);
            chk("R4", "cas", cas_o, e_cas);
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        run(3);
        rst_n = 1'b1; en = 1'b1;
        // Sweep both modes over all grades; changes land mid-loop (R9)
        for (int m = 0; m < 2; m++) begin
            for (int g = 0; g < 4; g++) begin
                mode_i = m[0]; grade_i = g[1:0];
                run(27);
            end
        end
        // Enable gaps (R11)
        for (int k = 0; k < 12; k++) begin
            en = k[0]; run(1 + (k % 3));
        end
        en = 1'b1; mode_i = 1'b0; grade_i = 2'd2;
        run(15);
        // Mid-run reset (R10)
        rst_n = 1'b0; run(2);
        rst_n = 1'b1; mode_i = 1'b1; grade_i = 2'd1;
        run(30);
        en = 1'b0; run(4);
        en = 1'b1; run(22);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #40000;
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=0", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule